// File: doc/BRIEF.md
# ASCII Hex Command Word Assembler

This block sits behind a serial receiver. It turns a stream of received bytes into fixed-width command words. Each byte arrives with a one-cycle valid strobe.

Printable characters in the range 0x30 to 0x3F each stand for one hexadecimal digit, and each one is shifted into a 52-bit accumulator. A space empties the accumulator. A carriage return publishes the accumulated word to the command executor and raises a one-cycle valid pulse. The published word is presented in three fields: a 4-bit opcode, a 5-bit register selector and a 43-bit auxiliary value.

The executor reads the fields on the cycle where the pulse is high. The fields hold their value until the next publication, so slower logic may also sample them later.

Top module: `hex_cmd_assembler`

## Requirements
- R1: With `rx_valid` high, a byte in 0x30..0x3F is a digit whose value is its low four bits ('0'..'9' give 0..9, ':' ';' '<' '=' '>' '?' give A..F). The accumulator then becomes `{acc[47:0], digit}`, so the digit received last is least significant.
- R2: When more than 13 digits arrive before a carriage return, only the last 13 are kept and the older digits are dropped off the top.
- R3: A valid byte that is neither a digit, 0x0D nor 0x20 has no effect: the accumulator keeps its value and no pulse is produced.
- R4: A valid 0x20 byte sets the accumulator to zero and produces no pulse.
- R5: A valid 0x0D byte accepted at a clock edge drives `cmd_valid` high for exactly the clock cycle that follows that edge.
- R6: The published word appears as `cmd_opcode` = bits [51:48], `cmd_reg` = bits [47:43] and `cmd_aux` = bits [42:0]. These outputs change only together with a `cmd_valid` pulse and hold their value between pulses.
- R7: Publishing also empties the accumulator, so the next command starts from zero.
- R8: Bytes presented while `rx_valid` is low have no effect.
- R9: While `rst_n` is low, `cmd_valid` is low, all three fields are zero and the accumulator is empty.
- R10: Carriage returns on consecutive cycles give consecutive pulses. The second pulse publishes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` as a new byte |
| cmd_valid | output | 1 | One-cycle pulse when a command word is published |
| cmd_opcode | output | 4 | Opcode field of the published word |
| cmd_reg | output | 5 | Register-select field of the published word |
| cmd_aux | output | 43 | Auxiliary field of the published word |

## Verification
The bench sends strings that use every digit character in both orders. A digit mapped to a wrong nibble, or nibbles placed in reverse, therefore shows up as a wrong field value.

Several other patterns each isolate one mechanism:
- Strings that mix in letters and punctuation separate correct filtering of non-digit bytes from a decoder that is too permissive.
- A 16-digit string separates truncation to the newest digits from truncation to the oldest.
- Strings broken by a space separate clearing from ignoring.
- Empty commands, back-to-back carriage returns, bytes held while the strobe is low, and a reset in the middle of a command show whether the accumulator really returns to zero after each publication.

// File: rtl/hca_pkg.sv
package hca_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned BYTE_W  = 8;

  // Control byte codes
  localparam logic [BYTE_W-1:0] CODE_COMMIT = 8'h0D;
  localparam logic [BYTE_W-1:0] CODE_CLEAR  = 8'h20;
  // Digit range: upper nibble selects the range, lower nibble is the value
  localparam logic [DIGIT_W-1:0] DIGIT_PAGE = 4'h3;

  typedef enum logic [1:0] {
    CC_NONE   = 2'd0,
    CC_DIGIT  = 2'd1,
    CC_COMMIT = 2'd2,
    CC_CLEAR  = 2'd3
  } char_class_e;

endpackage

// File: rtl/hca_char_decode.sv
module hca_char_decode
  import hca_pkg::*;
(
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               strobe_i,
  output char_class_e        class_o,
  output logic [DIGIT_W-1:0] digit_o
);

  logic is_digit;
  logic is_commit;
  logic is_clear;

  always_comb begin
    is_digit  = (byte_i[BYTE_W-1:DIGIT_W] == DIGIT_PAGE);
    is_commit = (byte_i == CODE_COMMIT);
    is_clear  = (byte_i == CODE_CLEAR);
  end

  always_comb begin
    class_o = CC_NONE;
    if (strobe_i) begin
      if (is_digit) begin
        class_o = CC_DIGIT;
      end else if (is_commit) begin
        class_o = CC_COMMIT;
      end else if (is_clear) begin
        class_o = CC_CLEAR;
      end
    end
  end

  assign digit_o = byte_i[DIGIT_W-1:0];

endmodule

// File: rtl/hca_digit_shifter.sv
module hca_digit_shifter
  import hca_pkg::*;
#(
  parameter int unsigned SLOTS = 13,
  localparam int unsigned ACC_W = SLOTS * DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  char_class_e        class_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [ACC_W-1:0]   acc_o
);

  logic [DIGIT_W-1:0] slot_q [SLOTS];
  logic [DIGIT_W-1:0] slot_d [SLOTS];
  logic               shift_en;
  logic               wipe_en;
  logic               slot_en;

  always_comb begin
    shift_en = (class_i == CC_DIGIT);
    wipe_en  = (class_i == CC_CLEAR) || (class_i == CC_COMMIT);
    slot_en  = shift_en || wipe_en;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_comb begin
        slot_d[i] = slot_q[i];
        if (wipe_en) begin
          slot_d[i] = '0;
        end else if (shift_en) begin
          slot_d[i] = digit_i;
        end
      end
    end else begin : g_body
      always_comb begin
        slot_d[i] = slot_q[i];
        if (wipe_en) begin
          slot_d[i] = '0;
        end else if (shift_en) begin
          slot_d[i] = slot_q[i-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (slot_en) begin
        slot_q[i] <= slot_d[i];
      end
    end

    assign acc_o[i*DIGIT_W +: DIGIT_W] = slot_q[i];
  end

endmodule

// File: rtl/hca_cmd_publish.sv
module hca_cmd_publish
  import hca_pkg::*;
#(
  parameter int unsigned WORD_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  char_class_e       class_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic              pulse_o,
  output logic [WORD_W-1:0] word_o
);

  logic              fire;
  logic              pulse_d;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    fire    = (class_i == CC_COMMIT);
    pulse_d = fire;
    word_d  = word_o;
    if (fire) begin
      word_d = acc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
    end else if (fire) begin
      word_o <= word_d;
    end
  end

endmodule

// File: rtl/hex_cmd_assembler.sv
module hex_cmd_assembler
  import hca_pkg::*;
#(
  parameter int unsigned OPC_W = 4,
  parameter int unsigned SEL_W = 5,
  parameter int unsigned AUX_W = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             cmd_valid,
  output logic [OPC_W-1:0] cmd_opcode,
  output logic [SEL_W-1:0] cmd_reg,
  output logic [AUX_W-1:0] cmd_aux
);

  localparam int unsigned WORD_W = OPC_W + SEL_W + AUX_W;
  localparam int unsigned SLOTS  = WORD_W / DIGIT_W;

  char_class_e        cls;
  logic [DIGIT_W-1:0] digit;
  logic [WORD_W-1:0]  acc;
  logic [WORD_W-1:0]  word;

  hca_char_decode u_decode (
    .byte_i   (rx_data),
    .strobe_i (rx_valid),
    .class_o  (cls),
    .digit_o  (digit)
  );

  hca_digit_shifter #(.SLOTS(SLOTS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .class_i (cls),
    .digit_i (digit),
    .acc_o   (acc)
  );

  hca_cmd_publish #(.WORD_W(WORD_W)) u_pub (
    .clk     (clk),
    .rst_n   (rst_n),
    .class_i (cls),
    .acc_i   (acc),
    .pulse_o (cmd_valid),
    .word_o  (word)
  );

  assign cmd_opcode = word[WORD_W-1 -: OPC_W];
  assign cmd_reg    = word[AUX_W +: SEL_W];
  assign cmd_aux    = word[AUX_W-1:0];

endmodule

// File: rtl/hca_checker.sv
module hca_checker #(
  parameter int unsigned OPC_W = 4,
  parameter int unsigned SEL_W = 5,
  parameter int unsigned AUX_W = 43
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rx_data,
  input logic             rx_valid,
  input logic             cmd_valid,
  input logic [OPC_W-1:0] cmd_opcode,
  input logic [SEL_W-1:0] cmd_reg,
  input logic [AUX_W-1:0] cmd_aux
);

  logic commit_in;
  logic clear_in;
  logic other_in;

  assign commit_in = rx_valid && (rx_data == 8'h0D);
  assign clear_in  = rx_valid && (rx_data == 8'h20);
  assign other_in  = rx_valid && (rx_data[7:4] != 4'h3) && !commit_in && !clear_in;

  // R5: a pulse follows every accepted carriage return
  a_r5_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    commit_in |=> cmd_valid);

  // R5: no pulse without a carriage return on the previous edge
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_in |=> !cmd_valid);

  // R4: a clear character never publishes
  a_r4_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
    clear_in |=> !cmd_valid);

  // R3: an ignored byte never publishes
  a_r3_other_silent: assert property (@(posedge clk) disable iff (!rst_n)
    other_in |=> !cmd_valid);

  // R6: fields move only with a pulse
  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable({cmd_opcode, cmd_reg, cmd_aux}));

  // R9: outputs held idle during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_idle: assert (!cmd_valid && cmd_opcode == '0 && cmd_reg == '0 && cmd_aux == '0);
    end
  end

endmodule

bind hex_cmd_assembler hca_checker #(
  .OPC_W(OPC_W), .SEL_W(SEL_W), .AUX_W(AUX_W)
) u_chk (.*);

// File: tb/hex_cmd_assembler_tb.sv
module hex_cmd_assembler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [7:0]   len;
    logic [127:0] text;
    logic [51:0]  expw;
  } vec_t;

  // text is right-justified: first character is the highest used byte
  localparam vec_t VECS [NVEC] = '{
    '{8'd13, 128'("0123456789:;<"),    52'h0123456789ABC},  // R1 ascending
    '{8'd13, 128'("?>=<;:9876543"),    52'hFEDCBA9876543},  // R1 descending
    '{8'd5,  128'("1G2z3"),            52'h0000000000123},  // R3 ignored letters
    '{8'd16, 128'("0123456789:;<=>?"), 52'h3456789ABCDEF},  // R2 overflow
    '{8'd5,  128'("77 12"),            52'h0000000000012},  // R4 clear mid-way
    '{8'd0,  128'(0),                  52'h0}               // R7 empty command
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        cmd_valid;
  logic [3:0]  cmd_opcode;
  logic [4:0]  cmd_reg;
  logic [42:0] cmd_aux;

  int n_run;
  int n_fail;
  logic done;

  hex_cmd_assembler u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_reg    (cmd_reg),
    .cmd_aux    (cmd_aux)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [51:0] w);
    check(cmd_opcode == w[51:48], req, 64'(cmd_opcode), 64'(w[51:48]));
    check(cmd_reg    == w[47:43], req, 64'(cmd_reg),    64'(w[47:43]));
    check(cmd_aux    == w[42:0],  req, 64'(cmd_aux),    64'(w[42:0]));
  endtask

  // Drive one byte for one cycle; returns at the falling edge after acceptance
  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic commit_and_check(input string req, input logic [51:0] w);
    send_byte(8'h0D);
    check(cmd_valid == 1'b1, req, 64'(cmd_valid), 64'd1);
    check_word(req, w);
    @(negedge clk);
    check(cmd_valid == 1'b0, "R5 single pulse", 64'(cmd_valid), 64'd0);
    check_word("R6 hold", w);
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    rx_data  = 8'h00;
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(cmd_valid == 1'b0, "R9 reset valid", 64'(cmd_valid), 64'd0);
    check_word("R9 reset fields", 52'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of vectors (R1, R2, R3, R4, R7)
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        send_byte(VECS[v].text[8*(int'(VECS[v].len)-1-i) +: 8]);
        check(cmd_valid == 1'b0, "R3 no pulse before commit", 64'(cmd_valid), 64'd0);
      end
      commit_and_check($sformatf("R1 vector %0d", v), VECS[v].expw);
    end

    // R8: strobe low, bytes ignored
    send_byte(8'h3A);
    rx_data = 8'h35;
    repeat (3) @(negedge clk);
    rx_data = 8'h0D;
    repeat (2) @(negedge clk);
    check(cmd_valid == 1'b0, "R8 no pulse with strobe low", 64'(cmd_valid), 64'd0);
    commit_and_check("R8 idle bytes ignored", 52'hA);

    // R10: back-to-back carriage returns
    send_byte(8'h39);
    rx_data  = 8'h0D;
    rx_valid = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b1, "R10 first pulse", 64'(cmd_valid), 64'd1);
    check_word("R10 first word", 52'h9);
    @(negedge clk);
    rx_valid = 1'b0;
    check(cmd_valid == 1'b1, "R10 second pulse", 64'(cmd_valid), 64'd1);
    check_word("R10 second word zero", 52'h0);
    @(negedge clk);
    check(cmd_valid == 1'b0, "R10 pulses end", 64'(cmd_valid), 64'd0);

    // R4: clear then commit publishes zero
    send_byte(8'h3F);
    send_byte(8'h3E);
    send_byte(8'h20);
    check(cmd_valid == 1'b0, "R4 clear silent", 64'(cmd_valid), 64'd0);
    commit_and_check("R4 cleared word", 52'h0);

    // R6: opcode and register fields with full-width word
    for (int i = 0; i < 13; i++) send_byte(8'h3F);
    commit_and_check("R6 all ones", 52'hFFFFFFFFFFFFF);
    send_byte(8'h3C); send_byte(8'h3F);
    for (int i = 0; i < 11; i++) send_byte(8'h30);
    commit_and_check("R6 opcode and reg split", 52'hCF00000000000);

    // R9: reset in the middle of a command
    send_byte(8'h35);
    send_byte(8'h35);
    rst_n = 1'b0;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9 mid reset valid", 64'(cmd_valid), 64'd0);
    check_word("R9 mid reset fields", 52'h0);
    rst_n = 1'b1;
    @(negedge clk);
    commit_and_check("R9 accumulator emptied by reset", 52'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule